// File: doc/BRIEF.md
# Slave Synchronous Serial Port

This block is a slave-only synchronous serial port for peripherals that do not use a stereo audio framing. An external device supplies the serial bit clock and a one-bit-wide frame sync. The transmitter and the receiver both use these two signals. The port never drives a clock. The block samples the serial clock, frame sync and receive data into the system clock domain and finds the serial clock edges there, so all of its state lives in one clock domain. It runs beside any other serial port on the chip without interacting with it.

Software sets the port up through a small register bus: word length (8, 16 or 24 bits), single-word or time-slot framing, slot count and a per-slot transmit enable mask. Software then supplies transmit words and collects receive words. Each direction holds one word. Flags report when the transmit word has been taken and when a receive word is waiting. Two sticky flags record a transmit slot that found no data and a receive word that was overwritten. In time-slot mode a slot whose mask bit is clear leaves the data pin undriven, shown by a low output enable.

Top module: `ssi_slave`

## Requirements
- R1: After reset the status register reads 0x1 (transmit-empty set, receive-full and both sticky flags clear) and `ser_oe` is low.
- R2: In single-word mode one word is sent per frame, MSB first. The first data bit goes out in the bit period that follows the bit period in which `ser_fs` is high. Transmit data changes after a rising `ser_clk` edge. Receive data is sampled on a falling edge.
- R3: A received word is placed right-aligned in RXDATA (address 3) with zero-filled upper bits, and receive-full (status bit 1) is set. A read of RXDATA clears receive-full.
- R4: Word-length code CTRL[1:0] selects 0 = 8, 1 = 16, 2 or 3 = 24 bits. The code, together with the mode and slot count, is captured when the frame sync is sampled. A change written during a frame takes effect at the next frame.
- R5: In time-slot mode (CTRL[2] = 1) the frame holds CTRL[7:3] + 1 consecutive slots of one word each. Every slot is received.
- R6: In time-slot mode, bit i of MASK (address 1) enables transmission in slot i. A disabled slot keeps `ser_oe` low and does not consume the transmit word. In single-word mode the mask has no effect.
- R7: An enabled slot that starts while transmit-empty is set sends all zeros with `ser_oe` high and sets the underrun flag (status bit 2).
- R8: A word that completes while receive-full is set replaces the held word and sets the overrun flag (status bit 3).
- R9: Both sticky flags hold until any write to STATUS (address 4), which clears them.
- R10: With CTRL[8] (enable) clear, frame syncs are ignored. No word is sent or received, transmit-empty is unchanged and `ser_oe` stays low.
- R11: Writing TXDATA (address 2) clears transmit-empty (status bit 0). The word being taken at the start of an enabled slot sets it.
- R12: `ser_oe` is low during the frame sync bit and between frames, and high for every bit of an enabled slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address: 0 CTRL, 1 MASK, 2 TXDATA, 3 RXDATA, 4 STATUS |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ser_clk | input | 1 | External serial bit clock |
| ser_fs | input | 1 | External frame sync, one bit period wide |
| ser_din | input | 1 | Serial receive data |
| ser_dout | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Transmit data pin drive enable |

## Verification
The bench builds the block with its default of two synchronizer stages. It toggles the serial clock every eight system cycles, which leaves each half bit period wide enough for the synchronizer and edge-detect latency. This reaches all three word lengths, the duplicate 24-bit code and a word-length change made in the middle of a frame. It also covers a four-slot time-slot frame with one masked slot, in which the transmit word is refilled between slots. The default slot-field width puts the 32-slot limit in range, but the bench only runs four slots.

// File: rtl/ssi_pkg.sv
// Package: shared constants, register addresses and configuration type
// for the slave synchronous serial port.
package ssi_pkg;
    localparam int unsigned BUS_W    = 32;
    localparam int unsigned WORD_MAX = 24;
    localparam int unsigned NSLOT    = 32;
    localparam int unsigned SLOT_W   = $clog2(NSLOT);
    localparam int unsigned BIT_W    = $clog2(WORD_MAX + 1);

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MASK = 3'd1,
        A_TXD  = 3'd2,
        A_RXD  = 3'd3,
        A_STAT = 3'd4
    } reg_addr_e;

    // Packed so that it maps directly onto CTRL[8:0].
    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slots_m1;
        logic              net;
        logic [1:0]        wsize;
    } ssi_cfg_t;

    // Word length in bits for a size code; codes 2 and 3 both mean 24.
    function automatic logic [BIT_W-1:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    word_bits = BIT_W'(8);
            2'd1:    word_bits = BIT_W'(16);
            default: word_bits = BIT_W'(24);
        endcase
    endfunction
endpackage

// File: rtl/ssi_sync_edge.sv
// Module: ssi_sync_edge
// Moves N asynchronous serial pins into the system clock domain through
// STAGES flip-flops. It then reports the rising and falling edges of bit 0
// (the serial clock). All bits go through the same number of stages, so a
// data or sync bit stays aligned with the clock edge it belongs to.
// Assumes the serial clock half period is several system clocks long.
module ssi_sync_edge #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned N      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced,
    output logic         rise,
    output logic         fall
);
    logic [N-1:0] pipe [STAGES];
    logic         clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= raw;
                end
            end else begin : g_next
                // Later stage: pass the previous stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign synced = pipe[STAGES-1];

    // Remember last synchronized serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= synced[0];
    end

    assign rise = synced[0] & ~clk_prev;
    assign fall = ~synced[0] & clk_prev;
endmodule

// File: rtl/ssi_regs.sv
// Module: ssi_regs
// Register file: configuration, slot mask, transmit and receive holding
// words, and the status flags. Decoded strobes come from the top. Events
// from the datapath set flags; bus writes clear or reload them.
// Assumes at most one bus access per cycle.
module ssi_regs
    import ssi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic                wr_ctrl,
    input  logic                wr_mask,
    input  logic                wr_tx,
    input  logic                wr_stat,
    input  logic                rd_rx,
    input  logic                tx_take,
    input  logic                undr_evt,
    input  logic                rx_valid,
    input  logic [WORD_MAX-1:0] rx_word,
    output ssi_cfg_t            cfg,
    output logic [NSLOT-1:0]    mask,
    output logic [WORD_MAX-1:0] tx_hold,
    output logic                tx_empty,
    output logic                rx_full,
    output logic                flag_undr,
    output logic                flag_ovr,
    output logic [BUS_W-1:0]    rdata
);
    logic [WORD_MAX-1:0] rx_hold;

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            mask <= '1;
        end else begin
            if (wr_ctrl) cfg  <= ssi_cfg_t'(wdata[$bits(ssi_cfg_t)-1:0]);
            if (wr_mask) mask <= wdata[NSLOT-1:0];
        end
    end

    // Transmit holding word; a write wins over a same-cycle take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tx) begin
            tx_hold  <= wdata[WORD_MAX-1:0];
            tx_empty <= 1'b0;
        end else if (tx_take) begin
            tx_empty <= 1'b1;
        end
    end

    // Receive holding word; a new word wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
        end else if (rx_valid) begin
            rx_hold <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_rx) begin
            rx_full <= 1'b0;
        end
    end

    // Sticky error flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_undr <= 1'b0;
            flag_ovr  <= 1'b0;
        end else begin
            if (undr_evt)               flag_undr <= 1'b1;
            else if (wr_stat)           flag_undr <= 1'b0;
            if (rx_valid && rx_full)    flag_ovr  <= 1'b1;
            else if (wr_stat)           flag_ovr  <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata[$bits(ssi_cfg_t)-1:0] = cfg;
            A_MASK: rdata[NSLOT-1:0]            = mask;
            A_TXD:  rdata[WORD_MAX-1:0]         = tx_hold;
            A_RXD:  rdata[WORD_MAX-1:0]         = rx_hold;
            A_STAT: rdata[3:0] = {flag_ovr, flag_undr, rx_full, tx_empty};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssi_frame_ctl.sv
// Module: ssi_frame_ctl
// Frame sequencer. A frame sync seen on a falling serial edge starts a
// frame and captures the configuration for it. Each word starts on the
// next rising edge, and its bits are counted on falling edges. In
// time-slot mode the words follow each other up to the captured slot
// count. A sync seen in the middle of a word restarts the frame.
// Assumes rise and fall never occur in the same cycle.
module ssi_frame_ctl
    import ssi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ssi_cfg_t          cfg,
    input  logic              rise,
    input  logic              fall,
    input  logic              fs,
    output logic              word_start,
    output logic              bit_shift,
    output logic              rx_sample,
    output logic              rx_last,
    output logic              in_word,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  f_wbits,
    output logic              f_net
);
    logic              start_pend;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] f_slots_m1;
    logic              last_bit;

    assign last_bit = (bit_idx == f_wbits - BIT_W'(1));

    // Frame, slot and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            in_word    <= 1'b0;
            bit_idx    <= '0;
            slot_idx   <= '0;
            f_slots_m1 <= '0;
            f_wbits    <= BIT_W'(8);
            f_net      <= 1'b0;
        end else if (!cfg.en) begin
            start_pend <= 1'b0;
            in_word    <= 1'b0;
        end else if (fall) begin
            if (fs) begin
                start_pend <= 1'b1;
                in_word    <= 1'b0;
                bit_idx    <= '0;
                slot_idx   <= '0;
                f_slots_m1 <= cfg.slots_m1;
                f_wbits    <= word_bits(cfg.wsize);
                f_net      <= cfg.net;
            end else if (in_word) begin
                if (last_bit) begin
                    in_word <= 1'b0;
                    bit_idx <= '0;
                    if (f_net && slot_idx != f_slots_m1) begin
                        start_pend <= 1'b1;
                        slot_idx   <= slot_idx + SLOT_W'(1);
                    end
                end else begin
                    bit_idx <= bit_idx + BIT_W'(1);
                end
            end
        end else if (rise && start_pend) begin
            start_pend <= 1'b0;
            in_word    <= 1'b1;
        end
    end

    assign word_start = cfg.en & rise & start_pend;
    assign bit_shift  = cfg.en & rise & in_word & ~start_pend;
    assign rx_sample  = cfg.en & fall & in_word & ~fs;
    assign rx_last    = rx_sample & last_bit;
endmodule

// File: rtl/ssi_tx_path.sv
// Module: ssi_tx_path
// Transmit shifter. At the start of each slot it either takes the holding
// word (left-aligned so the MSB leads) or sends zeros on underrun, or it
// stays undriven when the slot is masked. It shifts on each later rising
// edge of the word.
// Assumes word_start and bit_shift come from the same rising edge logic.
module ssi_tx_path
    import ssi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                rise,
    input  logic                in_word,
    input  logic                word_start,
    input  logic                bit_shift,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic                f_net,
    input  logic [BIT_W-1:0]    f_wbits,
    input  logic [NSLOT-1:0]    mask,
    input  logic [WORD_MAX-1:0] tx_hold,
    input  logic                tx_empty,
    output logic                tx_take,
    output logic                undr_evt,
    output logic                sd_out,
    output logic                oe
);
    logic [WORD_MAX-1:0] sh;
    logic                slot_on;
    logic [WORD_MAX-1:0] aligned;

    assign slot_on  = ~f_net | mask[slot_idx];
    assign aligned  = tx_hold << (BIT_W'(WORD_MAX) - f_wbits);
    assign tx_take  = word_start & slot_on & ~tx_empty;
    assign undr_evt = word_start & slot_on & tx_empty;

    // Shift register and pin enable update on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (!en) begin
            oe <= 1'b0;
        end else if (word_start) begin
            oe <= slot_on;
            sh <= tx_take ? aligned : '0;
        end else if (bit_shift) begin
            sh <= {sh[WORD_MAX-2:0], 1'b0};
        end else if (rise && !in_word) begin
            oe <= 1'b0;
        end
    end

    assign sd_out = sh[WORD_MAX-1];
endmodule

// File: rtl/ssi_rx_path.sv
// Module: ssi_rx_path
// Receive shifter. It samples a bit on each falling edge of a word. On
// the last bit it presents the word right-aligned and masked to the frame
// word length, with a one-cycle valid pulse.
// Assumes rx_last is only raised together with rx_sample.
module ssi_rx_path
    import ssi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_sample,
    input  logic                rx_last,
    input  logic                sd_in,
    input  logic [BIT_W-1:0]    f_wbits,
    output logic                rx_valid,
    output logic [WORD_MAX-1:0] rx_word
);
    logic [WORD_MAX-1:0] sh;
    logic [WORD_MAX-1:0] nxt;

    assign nxt = {sh[WORD_MAX-2:0], sd_in};

    // Sample serial data and emit completed words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= rx_last;
            if (rx_sample) sh <= nxt;
            if (rx_last)   rx_word <= nxt & ~({WORD_MAX{1'b1}} << f_wbits);
        end
    end
endmodule

// File: rtl/ssi_slave.sv
// Module: ssi_slave (top)
// Slave synchronous serial port: pin synchronizer, register file, frame
// sequencer, transmit and receive shifters. Register strobes are decoded
// here. Assumes the external serial clock is much slower than clk.
module ssi_slave
    import ssi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ser_clk,
    input  logic             ser_fs,
    input  logic             ser_din,
    output logic             ser_dout,
    output logic             ser_oe
);
    logic [2:0]          pins;
    logic                rise, fall;
    logic                wr_ctrl, wr_mask, wr_tx, wr_stat, rd_rx;
    ssi_cfg_t            cfg;
    logic                cfg_en;
    logic [NSLOT-1:0]    mask;
    logic [WORD_MAX-1:0] tx_hold;
    logic                tx_empty, rx_full, flag_undr, flag_ovr;
    logic                tx_take, undr_evt;
    logic                rx_valid;
    logic [WORD_MAX-1:0] rx_word;
    logic                word_start, bit_shift, rx_sample, rx_last, in_word;
    logic [SLOT_W-1:0]   slot_idx;
    logic [BIT_W-1:0]    f_wbits;
    logic                f_net;

    assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
    assign wr_mask = bus_wr & (bus_addr == A_MASK);
    assign wr_tx   = bus_wr & (bus_addr == A_TXD);
    assign wr_stat = bus_wr & (bus_addr == A_STAT);
    assign rd_rx   = bus_rd & (bus_addr == A_RXD);
    assign cfg_en  = cfg.en;

    ssi_sync_edge #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw({ser_din, ser_fs, ser_clk}),
        .synced(pins), .rise(rise), .fall(fall)
    );

    ssi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr_ctrl(wr_ctrl), .wr_mask(wr_mask), .wr_tx(wr_tx),
        .wr_stat(wr_stat), .rd_rx(rd_rx),
        .tx_take(tx_take), .undr_evt(undr_evt),
        .rx_valid(rx_valid), .rx_word(rx_word),
        .cfg(cfg), .mask(mask), .tx_hold(tx_hold), .tx_empty(tx_empty),
        .rx_full(rx_full), .flag_undr(flag_undr), .flag_ovr(flag_ovr),
        .rdata(bus_rdata)
    );

    ssi_frame_ctl u_frame (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .rise(rise), .fall(fall),
        .fs(pins[1]), .word_start(word_start), .bit_shift(bit_shift),
        .rx_sample(rx_sample), .rx_last(rx_last), .in_word(in_word),
        .slot_idx(slot_idx), .f_wbits(f_wbits), .f_net(f_net)
    );

    ssi_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .rise(rise),
        .in_word(in_word), .word_start(word_start), .bit_shift(bit_shift),
        .slot_idx(slot_idx), .f_net(f_net), .f_wbits(f_wbits),
        .mask(mask), .tx_hold(tx_hold), .tx_empty(tx_empty),
        .tx_take(tx_take), .undr_evt(undr_evt),
        .sd_out(ser_dout), .oe(ser_oe)
    );

    ssi_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sample(rx_sample), .rx_last(rx_last),
        .sd_in(pins[2]), .f_wbits(f_wbits),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );
endmodule

// File: rtl/ssi_slave_chk.sv
// Module: ssi_slave_chk
// Property checker for ssi_slave, attached with bind below. It relates
// bus strobes, datapath events and the resulting flag and pin state.
module ssi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_en,
    input logic oe,
    input logic tx_empty,
    input logic rx_full,
    input logic f_undr,
    input logic f_ovr,
    input logic wr_tx,
    input logic wr_stat,
    input logic rd_rx,
    input logic rx_valid
);
    p_disabled_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !oe);

    p_txwrite_fills_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> !tx_empty);

    p_rxread_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_valid) |=> !rx_full);

    p_undr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_undr && !wr_stat) |=> f_undr);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ovr && !wr_stat) |=> f_ovr);

    p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_ovr) |-> $past(rx_full));
endmodule

bind ssi_slave ssi_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_en(cfg_en), .oe(ser_oe),
    .tx_empty(tx_empty), .rx_full(rx_full), .f_undr(flag_undr),
    .f_ovr(flag_ovr), .wr_tx(wr_tx), .wr_stat(wr_stat), .rd_rx(rd_rx),
    .rx_valid(rx_valid)
);

// File: tb/ssi_slave_bench.sv
// Directed bench for ssi_slave: one task per scenario, each self-checking.
module ssi_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_clk = 1'b0, ser_fs = 1'b0, ser_din = 1'b0;
    logic        ser_dout, ser_oe;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ssi_slave u_ssi_slave (.*);

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input logic [1:0] code, input bit net,
                                         input logic [4:0] sm1, input bit en);
        return {23'd0, en, sm1, net, code};
    endfunction

    // One serial bit period: rising edge with new inputs, sample, falling edge.
    task automatic sck_bit(input logic fsv, input logic d,
                           output logic dout, output logic doe);
        ser_clk = 1'b1; ser_fs = fsv; ser_din = d;
        repeat (7) @(negedge clk);
        dout = ser_dout; doe = ser_oe;
        @(negedge clk); ser_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w, input int nb,
                             output logic [23:0] got, output bit oe_all,
                             output bit oe_any);
        logic d, o;
        got = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int b = nb - 1; b >= 0; b--) begin
            sck_bit(1'b0, w[b], d, o);
            got[b] = d; oe_all &= o; oe_any |= o;
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        reg_read(3'd4, s);
        check(s == 32'h1, "R1 status after reset", s, 32'h1);
        check(ser_oe == 1'b0, "R1 oe after reset", {31'd0, ser_oe}, 32'h0);
    endtask

    // Single-word frame; checks TX bits, oe window, RX word and flags.
    task automatic t_normal(input logic [1:0] code, input int nb,
                            input logic [23:0] txw, input logic [23:0] rxw);
        logic [23:0] got; logic [31:0] r; logic d, o; bit oa, on;
        reg_write(3'd0, ctrl(code, 1'b0, 5'd0, 1'b1));
        reg_write(3'd2, {8'd0, txw});
        reg_read(3'd4, r);
        check(r[0] == 1'b0, "R11 tx_empty cleared by write", r, 32'h0);
        sck_bit(1'b1, 1'b0, d, o);
        check(o == 1'b0, "R12 oe low in sync bit", {31'd0, o}, 32'h0);
        send_word(rxw, nb, got, oa, on);
        check(got == (txw & ((24'd1 << nb) - 24'd1)) || nb == 24 && got == txw,
              "R2/R4 transmitted word", {8'd0, got}, {8'd0, txw});
        check(oa, "R12 oe high through word", {31'd0, oa}, 32'h1);
        sck_bit(1'b0, 1'b0, d, o);
        check(o == 1'b0, "R12 oe low after word", {31'd0, o}, 32'h0);
        reg_read(3'd4, r);
        check(r == 32'h3, "R3/R11 status after frame", r, 32'h3);
        reg_read(3'd3, r);
        check(r == {8'd0, rxw}, "R3 received word", r, {8'd0, rxw});
        reg_read(3'd4, r);
        check(r == 32'h1, "R3 rx_full cleared by read", r, 32'h1);
    endtask

    // Word-length change written mid-frame applies only to the next frame.
    task automatic t_size_latch();
        logic [23:0] got; logic [31:0] r; logic d, o; bit oa, on;
        reg_write(3'd0, ctrl(2'd0, 1'b0, 5'd0, 1'b1));
        reg_write(3'd2, 32'hA5);
        sck_bit(1'b1, 1'b0, d, o);
        reg_write(3'd0, ctrl(2'd2, 1'b0, 5'd0, 1'b1));
        send_word(24'h3C, 8, got, oa, on);
        sck_bit(1'b0, 1'b0, d, o);
        check(got == 24'hA5, "R4 tx keeps 8-bit length", {8'd0, got}, 32'hA5);
        reg_read(3'd3, r);
        check(r == 32'h3C, "R4 rx keeps 8-bit length", r, 32'h3C);
    endtask

    // Four 8-bit slots, slot 2 masked off; TX refilled between slots.
    task automatic t_network();
        logic [23:0] g; logic [31:0] r; logic d, o; bit oa, on;
        reg_write(3'd1, 32'hB);
        reg_write(3'd0, ctrl(2'd0, 1'b1, 5'd3, 1'b1));
        reg_write(3'd2, 32'h11);
        sck_bit(1'b1, 1'b0, d, o);
        send_word(24'h01, 8, g, oa, on);
        check(g == 24'h11 && oa, "R5 slot0 tx", {8'd0, g}, 32'h11);
        reg_read(3'd3, r);
        check(r == 32'h01, "R5 slot0 rx", r, 32'h01);
        reg_write(3'd2, 32'h82);
        send_word(24'h7E, 8, g, oa, on);
        check(g == 24'h82 && oa, "R5 slot1 tx", {8'd0, g}, 32'h82);
        reg_read(3'd3, r);
        check(r == 32'h7E, "R5 slot1 rx", r, 32'h7E);
        reg_write(3'd2, 32'hF0);
        send_word(24'h55, 8, g, oa, on);
        check(!on, "R6 masked slot undriven", {31'd0, on}, 32'h0);
        reg_read(3'd4, r);
        check(r[0] == 1'b0, "R6 masked slot keeps tx word", r, 32'h2);
        reg_read(3'd3, r);
        check(r == 32'h55, "R5 masked slot still received", r, 32'h55);
        send_word(24'hC8, 8, g, oa, on);
        check(g == 24'hF0 && oa, "R5 slot3 tx", {8'd0, g}, 32'hF0);
        sck_bit(1'b0, 1'b0, d, o);
        check(o == 1'b0, "R12 oe low after frame", {31'd0, o}, 32'h0);
        reg_read(3'd3, r);
        check(r == 32'hC8, "R5 slot3 rx", r, 32'hC8);
        reg_read(3'd4, r);
        check(r == 32'h1, "R5 status after net frame", r, 32'h1);
        reg_write(3'd1, 32'hFFFF_FFFF);
    endtask

    // Frame with no TX data: zeros sent, underrun sticky until status write.
    task automatic t_underrun();
        logic [23:0] g; logic [31:0] r; logic d, o; bit oa, on;
        reg_write(3'd0, ctrl(2'd0, 1'b0, 5'd0, 1'b1));
        sck_bit(1'b1, 1'b0, d, o);
        send_word(24'h00, 8, g, oa, on);
        sck_bit(1'b0, 1'b0, d, o);
        check(g == 24'h0 && oa, "R7 underrun sends zeros driven", {8'd0, g}, 32'h0);
        reg_read(3'd3, r);
        reg_read(3'd4, r);
        check(r == 32'h5, "R7 underrun flag set", r, 32'h5);
        reg_write(3'd2, 32'h1);
        reg_read(3'd4, r);
        check(r == 32'h4, "R9 underrun flag holds", r, 32'h4);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, r);
        check(r == 32'h0, "R9 status write clears underrun", r, 32'h0);
    endtask

    // Two frames without reading RX: second word kept, overrun sticky.
    task automatic t_overrun();
        logic [23:0] g; logic [31:0] r; logic d, o; bit oa, on;
        for (int f = 0; f < 2; f++) begin
            reg_write(3'd2, 32'h0);
            sck_bit(1'b1, 1'b0, d, o);
            send_word(f == 0 ? 24'h12 : 24'h34, 8, g, oa, on);
            sck_bit(1'b0, 1'b0, d, o);
        end
        reg_read(3'd4, r);
        check(r == 32'hB, "R8 overrun flag set", r, 32'hB);
        reg_read(3'd3, r);
        check(r == 32'h34, "R8 newer word kept", r, 32'h34);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, r);
        check(r == 32'h1, "R9 status write clears overrun", r, 32'h1);
    endtask

    // Port disabled: frame ignored at the pins and in the flags.
    task automatic t_disable();
        logic [23:0] g; logic [31:0] r; logic d, o; bit oa, on;
        reg_write(3'd0, ctrl(2'd0, 1'b0, 5'd0, 1'b0));
        reg_write(3'd2, 32'h77);
        sck_bit(1'b1, 1'b0, d, o);
        send_word(24'h99, 8, g, oa, on);
        sck_bit(1'b0, 1'b0, d, o);
        check(!on, "R10 oe stays low when disabled", {31'd0, on}, 32'h0);
        reg_read(3'd4, r);
        check(r == 32'h0, "R10 no flag change when disabled", r, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_normal(2'd0, 8, 24'hA5, 24'h5A);
        reg_write(3'd1, 32'h0);                       // R6: mask unused in single-word mode
        t_normal(2'd1, 16, 24'hC3E1, 24'h1234);
        reg_write(3'd1, 32'hFFFF_FFFF);
        t_normal(2'd2, 24, 24'h8F0F33, 24'hABCDEF);
        t_normal(2'd3, 24, 24'h700001, 24'h000081);
        t_size_latch();
        t_network();
        t_underrun();
        t_overrun();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule